// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block sits between a processing core and a shared external bus whose low sixteen lines carry an address first and data later. The core offers one transfer at a time: a 20-bit byte address, 16-bit write data, a direction bit, a memory-or-I/O bit and a byte-or-word bit. The block accepts the request on a valid/ready handshake and runs one bus cycle of four clock states, named T1, T2, T3 and T4. During T1 it drives the address and pulses the latch strobe so that external latches can hold it. From T2 onward the low lines carry data, and the top four lines carry a status nibble instead of address bits 19 to 16.

Slow devices stretch a cycle by holding READY low. The block samples READY on the clock edge that ends T2. While READY is low it inserts wait states (TW) between T2 and T3 and samples READY again at the end of each one. Read data is taken from the bus on the edge that ends T3, and the done pulse comes out in T4. A new request may be accepted in T4, and its T1 then follows T4 directly.

The high-byte enable and address bit 0 together select the active byte lanes. A word request at an odd address gets an error pulse and no bus cycle is run.

The states are ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3 and ST_T4. The transitions are:
- IDLE to T1 on an aligned accepted request.
- T1 to T2 always.
- T2 to T3 when READY is high, and T2 to TW when it is low.
- TW to TW while READY is low, and TW to T3 when it is high.
- T3 to T4 always.
- T4 to T1 on an aligned accepted request, and T4 to IDLE otherwise.

A misaligned request accepted in IDLE or T4 leads to IDLE.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset and while idle:
  - the strobes are inactive: bus_ale=0, bus_rd_n=1, bus_wr_n=1, bus_den_n=1;
  - bus_ad_oe=0, bus_bhe_n=1, bus_mio=0, bus_dtr=0;
  - rsp_done=0, rsp_err=0 and req_ready=1.
- R2: A request is taken when req_valid and req_ready are both high, and req_ready is high only in IDLE and T4. With READY high at every sample, an aligned request gives the following sequence:
  - T1 in the clock after it is taken;
  - then T2, T3 and T4 on consecutive clocks;
  - rsp_done=1 in T4 only;
  - bus_ale=1 in T1 only.
  A request taken in T4 starts its T1 in the next clock.
- R3: Each sample of READY=0, taken at the end of T2 or of a wait state, inserts exactly one wait state before T3. The first sample of READY=1 leads to T3.
- R4: In T1 the bus carries the address: bus_ad_out = addr[15:0], bus_as = addr[19:16] and bus_ad_oe=1.
- R5: From T2 to T4, bus_as carries the status nibble {write, io, byte, 1} (bit 3 down to bit 0).
- R6: Throughout T1 to T4, bus_bhe_n follows the byte lanes selected. With address bit 0 visible on bus_ad_out[0] in T1, the pair {bhe_n, a0} is 00 for a word, 01 for a byte at an odd address and 10 for a byte at an even address. The pair 11 never appears in a cycle.
- R7: bus_rd_n (for reads) or bus_wr_n (for writes) is low in T2, in every wait state and in T3, and high in T1 and T4. The two are never low together.
- R8: bus_dtr is 1 for writes and 0 for reads throughout T1 to T4. bus_den_n is low from T2 to T3 for reads and from T1 to T4 for writes.
- R9: For writes, bus_ad_oe=1 from T1 to T4. From T2 to T4 the bus carries the write data:
  - for a word, bus_ad_out = wdata;
  - for a byte, wdata[7:0] is placed on both lanes.
  For reads, bus_ad_oe=1 in T1 only.
- R10: A read captures bus_ad_in on the edge that ends T3, and rsp_rdata shows the captured value from T4 on:
  - for a word, the full 16 bits;
  - for a byte at an odd address, bus_ad_in[15:8] zero-extended;
  - for a byte at an even address, bus_ad_in[7:0] zero-extended.
- R11: A word request with addr[0]=1 runs no bus cycle and asserts no strobe. It gives rsp_err=1 for one clock, in the clock after it is taken, and no rsp_done.
- R12: bus_mio is 1 for memory cycles and 0 for I/O cycles throughout T1 to T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core offers a transfer |
| req_ready | output | 1 | Sequencer can take a transfer this clock |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_byte | input | 1 | 1 = byte transfer, 0 = word |
| rsp_rdata | output | 16 | Read data, valid from T4 of a read |
| rsp_done | output | 1 | One-clock completion pulse in T4 |
| rsp_err | output | 1 | One-clock pulse for a rejected misaligned word |
| bus_ad_out | output | 16 | Multiplexed address/data lines, output value |
| bus_ad_in | input | 16 | Multiplexed address/data lines, input value |
| bus_ad_oe | output | 1 | Output enable for the address/data lines |
| bus_as | output | 4 | Address bits 19:16 in T1, status nibble afterwards |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_mio | output | 1 | 1 = memory, 0 = I/O |
| bus_dtr | output | 1 | Data direction, 1 = transmit, 0 = receive |
| bus_den_n | output | 1 | Data buffer enable, active low |
| bus_bhe_n | output | 1 | High-byte enable, active low |
| bus_ready | input | 1 | Device ready, sampled at the end of T2 and of each wait state |

## Verification
The assertions assume that bus_ready is a clean synchronous level, settled before each sampling edge, and that a device never holds READY low forever. They also assume the core keeps its request fields stable while req_valid is high. The bench changes bus_ready, bus_ad_in and every request field only on falling edges. It returns READY to 1 after a bounded count of zero to three low samples, and it drops req_valid in the clock after a request is taken.

// File: rtl/bus_cycle_pkg.sv
package bus_cycle_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_TW,
        ST_T3,
        ST_T4
    } bus_state_e;

    // A word access must start on an even byte address.
    function automatic logic word_misaligned(input logic is_byte, input logic a0);
        return !is_byte && a0;
    endfunction

endpackage

// File: rtl/bus_cycle_fsm.sv
module bus_cycle_fsm
    import bus_cycle_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       bus_ready,
    output bus_state_e state
);

    bus_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = start ? ST_T1 : ST_IDLE;
            ST_T1:   state_nx = ST_T2;
            ST_T2:   state_nx = bus_ready ? ST_T3 : ST_TW;
            ST_TW:   state_nx = bus_ready ? ST_T3 : ST_TW;
            ST_T3:   state_nx = ST_T4;
            ST_T4:   state_nx = start ? ST_T1 : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/bus_cycle_lanes.sv
module bus_cycle_lanes #(
    parameter int DATA_W = 16
) (
    input  logic              is_byte,
    input  logic              a0,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ad_in,
    output logic              bhe_n,
    output logic [DATA_W-1:0] wbus,
    output logic [DATA_W-1:0] rlane
);

    localparam int HALF = DATA_W / 2;

    // Upper lane is active for words and for bytes at odd addresses.
    assign bhe_n = is_byte && !a0;

    // A byte write is copied onto both lanes; the device picks its lane.
    assign wbus = is_byte ? {2{wdata[HALF-1:0]}} : wdata;

    always_comb begin
        if (!is_byte) begin
            rlane = ad_in;
        end else if (a0) begin
            rlane = {{HALF{1'b0}}, ad_in[DATA_W-1:HALF]};
        end else begin
            rlane = {{HALF{1'b0}}, ad_in[HALF-1:0]};
        end
    end

endmodule

// File: rtl/bus_cycle_ctl.sv
module bus_cycle_ctl
    import bus_cycle_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  bus_state_e        state,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wbus,
    input  logic              is_write,
    input  logic              is_io,
    input  logic              is_byte,
    input  logic              bhe_n_lane,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   as_out,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              mio,
    output logic              dtr,
    output logic              den_n,
    output logic              bhe_n,
    output logic              ready_core,
    output logic              done
);

    logic [3:0] status_nib;
    logic       strobe;

    assign status_nib = {is_write, is_io, is_byte, 1'b1};

    always_comb begin
        ad_out     = '0;
        ad_oe      = 1'b0;
        as_out     = '0;
        ale        = 1'b0;
        strobe     = 1'b0;
        mio        = 1'b0;
        dtr        = 1'b0;
        den_n      = 1'b1;
        bhe_n      = 1'b1;
        ready_core = 1'b0;
        done       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ready_core = 1'b1;
            end
            ST_T1: begin
                ale    = 1'b1;
                ad_out = addr[DATA_W-1:0];
                ad_oe  = 1'b1;
                as_out = addr[ADDR_W-1:DATA_W];
                mio    = !is_io;
                dtr    = is_write;
                den_n  = !is_write;
                bhe_n  = bhe_n_lane;
            end
            ST_T2, ST_TW, ST_T3: begin
                strobe = 1'b1;
                ad_out = is_write ? wbus : '0;
                ad_oe  = is_write;
                as_out = HI_W'(status_nib);
                mio    = !is_io;
                dtr    = is_write;
                den_n  = 1'b0;
                bhe_n  = bhe_n_lane;
            end
            ST_T4: begin
                ad_out     = is_write ? wbus : '0;
                ad_oe      = is_write;
                as_out     = HI_W'(status_nib);
                mio        = !is_io;
                dtr        = is_write;
                den_n      = !is_write;
                bhe_n      = bhe_n_lane;
                ready_core = 1'b1;
                done       = 1'b1;
            end
            default: begin
                ready_core = 1'b0;
            end
        endcase
    end

    assign rd_n = !(strobe && !is_write);
    assign wr_n = !(strobe && is_write);

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bus_cycle_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_io,
    input  logic              req_byte,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] bus_ad_out,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic              bus_ad_oe,
    output logic [HI_W-1:0]   bus_as,
    output logic              bus_ale,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_mio,
    output logic              bus_dtr,
    output logic              bus_den_n,
    output logic              bus_bhe_n,
    input  logic              bus_ready
);

    bus_state_e        cyc_state;
    logic              take;
    logic              bad_align;
    logic              start;
    logic [ADDR_W-1:0] cyc_addr;
    logic [DATA_W-1:0] cyc_wdata;
    logic              cyc_write;
    logic              cyc_io;
    logic              cyc_byte;
    logic              lane_bhe_n;
    logic [DATA_W-1:0] lane_wbus;
    logic [DATA_W-1:0] lane_rdata;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;

    assign take      = req_valid && req_ready;
    assign bad_align = word_misaligned(req_byte, req_addr[0]);
    assign start     = take && !bad_align;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_addr  <= '0;
            cyc_wdata <= '0;
            cyc_write <= 1'b0;
            cyc_io    <= 1'b0;
            cyc_byte  <= 1'b0;
            err_q     <= 1'b0;
            rdata_q   <= '0;
        end else begin
            err_q <= take && bad_align;
            if (start) begin
                cyc_addr  <= req_addr;
                cyc_wdata <= req_wdata;
                cyc_write <= req_write;
                cyc_io    <= req_io;
                cyc_byte  <= req_byte;
            end
            if (cyc_state == ST_T3 && !cyc_write) begin
                rdata_q <= lane_rdata;
            end
        end
    end

    bus_cycle_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .bus_ready (bus_ready),
        .state     (cyc_state)
    );

    bus_cycle_lanes #(.DATA_W(DATA_W)) u_lanes (
        .is_byte (cyc_byte),
        .a0      (cyc_addr[0]),
        .wdata   (cyc_wdata),
        .ad_in   (bus_ad_in),
        .bhe_n   (lane_bhe_n),
        .wbus    (lane_wbus),
        .rlane   (lane_rdata)
    );

    bus_cycle_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
        .state      (cyc_state),
        .addr       (cyc_addr),
        .wbus       (lane_wbus),
        .is_write   (cyc_write),
        .is_io      (cyc_io),
        .is_byte    (cyc_byte),
        .bhe_n_lane (lane_bhe_n),
        .ad_out     (bus_ad_out),
        .ad_oe      (bus_ad_oe),
        .as_out     (bus_as),
        .ale        (bus_ale),
        .rd_n       (bus_rd_n),
        .wr_n       (bus_wr_n),
        .mio        (bus_mio),
        .dtr        (bus_dtr),
        .den_n      (bus_den_n),
        .bhe_n      (bus_bhe_n),
        .ready_core (req_ready),
        .done       (rsp_done)
    );

    assign rsp_rdata = rdata_q;
    assign rsp_err   = err_q;

endmodule

// File: rtl/bus_cycle_chk.sv
module bus_cycle_chk
    import bus_cycle_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input bus_state_e cyc_state,
    input logic       ale,
    input logic       rd_n,
    input logic       wr_n,
    input logic       den_n,
    input logic       dtr,
    input logic       ad_oe,
    input logic       ad_a0,
    input logic       bhe_n,
    input logic       ready,
    input logic       done,
    input logic       err
);

    AST_ALE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale); // R2

    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(!rd_n || !wr_n)); // R2

    AST_WAIT_ON_LOW_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_state == ST_T2 || cyc_state == ST_TW) && !ready) |=> (cyc_state == ST_TW)); // R3

    AST_LANE_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> !(bhe_n && ad_a0)); // R6

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R7

    AST_NO_STROBE_WITH_ALE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n)); // R7

    AST_READ_BUFFER_IN: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (!den_n && !dtr && !ad_oe)); // R8

    AST_WRITE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (!den_n && dtr && ad_oe)); // R9

    AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!ale && rd_n && wr_n && !done)); // R11

endmodule

bind bus_cycle_seq bus_cycle_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_state (cyc_state),
    .ale       (bus_ale),
    .rd_n      (bus_rd_n),
    .wr_n      (bus_wr_n),
    .den_n     (bus_den_n),
    .dtr       (bus_dtr),
    .ad_oe     (bus_ad_oe),
    .ad_a0     (bus_ad_out[0]),
    .bhe_n     (bus_bhe_n),
    .ready     (bus_ready),
    .done      (rsp_done),
    .err       (rsp_err)
);

// File: tb/bus_cycle_seq_tb_top.sv
module bus_cycle_seq_tb_top;

    localparam int PH_T1 = 1;
    localparam int PH_T2 = 2;
    localparam int PH_TW = 3;
    localparam int PH_T3 = 4;
    localparam int PH_T4 = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic        req_byte = 1'b0;
    logic [15:0] rsp_rdata;
    logic        rsp_done;
    logic        rsp_err;
    logic [15:0] bus_ad_out;
    logic [15:0] bus_ad_in = '0;
    logic        bus_ad_oe;
    logic [3:0]  bus_as;
    logic        bus_ale;
    logic        bus_rd_n;
    logic        bus_wr_n;
    logic        bus_mio;
    logic        bus_dtr;
    logic        bus_den_n;
    logic        bus_bhe_n;
    logic        bus_ready = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    bus_cycle_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_write  (req_write),
        .req_io     (req_io),
        .req_byte   (req_byte),
        .rsp_rdata  (rsp_rdata),
        .rsp_done   (rsp_done),
        .rsp_err    (rsp_err),
        .bus_ad_out (bus_ad_out),
        .bus_ad_in  (bus_ad_in),
        .bus_ad_oe  (bus_ad_oe),
        .bus_as     (bus_as),
        .bus_ale    (bus_ale),
        .bus_rd_n   (bus_rd_n),
        .bus_wr_n   (bus_wr_n),
        .bus_mio    (bus_mio),
        .bus_dtr    (bus_dtr),
        .bus_den_n  (bus_den_n),
        .bus_bhe_n  (bus_bhe_n),
        .bus_ready  (bus_ready)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic check_phase(input int ph, input logic wr, input logic io,
                               input logic by, input logic [19:0] addr,
                               input logic [15:0] wd);
        logic act;
        logic [15:0] wexp;
        act  = (ph == PH_T2) || (ph == PH_TW) || (ph == PH_T3);
        wexp = by ? {wd[7:0], wd[7:0]} : wd;
        chk("R2 ale", bus_ale, ph == PH_T1);
        chk("R2 done", rsp_done, ph == PH_T4);
        chk("R2 req_ready", req_ready, ph == PH_T4);
        chk("R7 rd_n", bus_rd_n, !(act && !wr));
        chk("R7 wr_n", bus_wr_n, !(act && wr));
        chk("R8 dtr", bus_dtr, wr);
        chk("R8 den_n", bus_den_n, wr ? 1'b0 : !act);
        chk("R12 mio", bus_mio, !io);
        chk("R6 bhe_n", bus_bhe_n, by && !addr[0]);
        if (ph == PH_T1) begin
            chk("R4 ad_out", bus_ad_out, addr[15:0]);
            chk("R4 as", bus_as, addr[19:16]);
            chk("R4 oe", bus_ad_oe, 1'b1);
            chk("R6 lane code", {bus_bhe_n, bus_ad_out[0]},
                by ? (addr[0] ? 2'b01 : 2'b10) : 2'b00);
        end else begin
            chk("R5 status", bus_as, {wr, io, by, 1'b1});
            chk("R9 oe", bus_ad_oe, wr);
            if (wr) chk("R9 wdata", bus_ad_out, wexp);
        end
    endtask

    logic        nx_wr, nx_io, nx_by;
    logic [19:0] nx_addr;
    logic [15:0] nx_wd;

    task automatic walk(input logic wr, input logic io, input logic by,
                        input logic [19:0] addr, input logic [15:0] wd,
                        input int waits, input logic [15:0] din, input bit chain);
        logic [15:0] rexp;
        check_phase(PH_T1, wr, io, by, addr, wd);
        @(negedge clk);
        check_phase(PH_T2, wr, io, by, addr, wd);
        bus_ready = (waits == 0);
        for (int k = 0; k < waits; k++) begin
            @(negedge clk);
            check_phase(PH_TW, wr, io, by, addr, wd);
            bus_ready = (k == waits - 1);
        end
        @(negedge clk);
        check_phase(PH_T3, wr, io, by, addr, wd);
        bus_ad_in = din;
        @(negedge clk);
        check_phase(PH_T4, wr, io, by, addr, wd);
        if (!wr) begin
            rexp = !by ? din : (addr[0] ? {8'h00, din[15:8]} : {8'h00, din[7:0]});
            chk("R10 rdata", rsp_rdata, rexp);
        end
        if (chain) begin
            req_addr  = nx_addr;
            req_wdata = nx_wd;
            req_write = nx_wr;
            req_io    = nx_io;
            req_byte  = nx_by;
            req_valid = 1'b1;
        end else begin
            @(negedge clk);
            chk("R1 idle ale", bus_ale, 1'b0);
            chk("R1 idle done", rsp_done, 1'b0);
            chk("R1 idle ready", req_ready, 1'b1);
            chk("R1 idle rd_n", bus_rd_n, 1'b1);
            chk("R1 idle wr_n", bus_wr_n, 1'b1);
        end
    endtask

    task automatic run_txn(input logic wr, input logic io, input logic by,
                           input logic [19:0] addr, input logic [15:0] wd,
                           input int waits, input logic [15:0] din);
        req_addr  = addr;
        req_wdata = wd;
        req_write = wr;
        req_io    = io;
        req_byte  = by;
        req_valid = 1'b1;
        bus_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (!by && addr[0]) begin
            chk("R11 err pulse", rsp_err, 1'b1);
            chk("R11 no ale", bus_ale, 1'b0);
            chk("R11 no rd", bus_rd_n, 1'b1);
            chk("R11 no wr", bus_wr_n, 1'b1);
            @(negedge clk);
            chk("R11 err single", rsp_err, 1'b0);
            chk("R11 no done", rsp_done, 1'b0);
            chk("R11 still idle", req_ready, 1'b1);
        end else begin
            walk(wr, io, by, addr, wd, waits, din, 1'b0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ale", bus_ale, 1'b0);
        chk("R1 reset rd_n", bus_rd_n, 1'b1);
        chk("R1 reset wr_n", bus_wr_n, 1'b1);
        chk("R1 reset den_n", bus_den_n, 1'b1);
        chk("R1 reset oe", bus_ad_oe, 1'b0);
        chk("R1 reset bhe_n", bus_bhe_n, 1'b1);
        chk("R1 reset mio", bus_mio, 1'b0);
        chk("R1 reset dtr", bus_dtr, 1'b0);
        chk("R1 reset done", rsp_done, 1'b0);
        chk("R1 reset err", rsp_err, 1'b0);
        chk("R1 reset ready", req_ready, 1'b1);

        // Full sweep over direction, space, size, address bit 0 and wait count (R3 waits 0..3).
        for (int idx = 0; idx < 64; idx++) begin
            logic        wr, io, by, a0;
            logic [19:0] addr;
            int          waits;
            wr    = idx[0];
            io    = idx[1];
            by    = idx[2];
            a0    = idx[3];
            waits = idx >> 4;
            addr  = 20'h92A40 + 20'(idx * 32'h10112);
            addr[0] = a0;
            run_txn(wr, io, by, addr, 16'h3C5A ^ 16'(idx * 16'h0917),
                    waits, 16'hA5C3 ^ 16'(idx * 16'h1203));
        end

        // Back-to-back: request taken in T4 starts T1 next clock (R2).
        req_addr  = 20'h4_1236;
        req_wdata = 16'h0000;
        req_write = 1'b0;
        req_io    = 1'b0;
        req_byte  = 1'b0;
        req_valid = 1'b1;
        bus_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        nx_addr = 20'hB_7E51;
        nx_wd   = 16'h6D2E;
        nx_wr   = 1'b1;
        nx_io   = 1'b1;
        nx_by   = 1'b1;
        walk(1'b0, 1'b0, 1'b0, 20'h4_1236, 16'h0000, 2, 16'hBEEF, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 back-to-back T1", bus_ale, 1'b1);
        walk(1'b1, 1'b1, 1'b1, 20'hB_7E51, 16'h6D2E, 1, 16'h0000, 1'b0);

        // Read data held across a write cycle (R10).
        chk("R10 rdata held", rsp_rdata, 16'hBEEF);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule